// File: doc/BRIEF.md
# Two-Wire Slave Front End for an Eight-Input Expander

This block is the serial-bus slave that sits between a two-wire bus and the transition detector of an eight-input expander. It samples the bus lines into the system clock domain and finds the START and STOP conditions. It shifts in the address byte together with its direction bit and compares the 7-bit address with a value supplied on a port. When the address matches, the block acknowledges it.

A write frame loads each data byte into an 8-bit interrupt mask. A read frame streams bytes back to the master without a register pointer. The first byte is the port snapshot and the second is the transition flags, and the pair repeats for as long as the master acknowledges. A negative acknowledge from the master ends the transfer. SDA is only ever pulled low or released.

The block also produces the strobes the transition detector needs. The resample strobe fires at the address acknowledge of a matching frame and at each master acknowledge that closes a flag byte. The stop strobe marks the end of a frame. A read-busy level lets the interrupt logic hold off while a read is in progress.

Top module: `i2cx_expander_slave`

## Requirements
- R1: After reset, sda_pull_o, ack_strobe_o, stop_strobe_o and rd_busy_o are 0 and irq_mask_o is 8'h00.
- R2: A STOP (SDA rising while SCL is high) releases SDA, clears rd_busy_o and pulses stop_strobe_o for one cycle. A START (SDA falling while SCL is high) restarts the address phase even in the middle of a frame, which gives a repeated START.
- R3: The address byte is taken MSB first: seven address bits, then the direction bit (1 means read). If the seven bits equal dev_addr_i, the block holds SDA low through the whole 9th clock.
- R4: If the address does not match, the block never pulls SDA for the rest of the frame. It leaves irq_mask_o unchanged and ignores every byte until the next START.
- R5: In a matching write frame, each data byte is received MSB first, acknowledged with SDA low on its 9th clock, and loaded into irq_mask_o. The last byte written wins. irq_mask_o never changes during a read.
- R6: In a matching read frame, the bytes go out MSB first in the order port_snap_i, trans_flags_i, port_snap_i, trans_flags_i, and so on. A 1 bit leaves SDA released and a 0 bit pulls it low.
- R7: When the master does not acknowledge a read byte (SDA high on the 9th clock), the block releases SDA and drives nothing more until the next START or STOP.
- R8: ack_strobe_o is a single-cycle pulse. It fires once at the address acknowledge of a matching frame, and once at every master acknowledge that follows a flag byte. A read of N bytes that ends in a NACK therefore gives 1 + (N-1)/2 pulses (integer division).
- R9: rd_busy_o is 1 while the block is sending a read byte or waiting for the master's acknowledge of it, and 0 otherwise.
- R10: sda_pull_o changes only while SCL is low. The block never drives SDA high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous to clk |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous to clk |
| dev_addr_i | input | 7 | Slave address to answer |
| port_snap_i | input | 8 | Port snapshot from the transition detector |
| trans_flags_i | input | 8 | Transition flags from the transition detector |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| irq_mask_o | output | 8 | Interrupt mask written by the master |
| ack_strobe_o | output | 1 | One-cycle resample/clear strobe for the detector |
| stop_strobe_o | output | 1 | One-cycle pulse on every STOP |
| rd_busy_o | output | 1 | A read transfer is in progress |

## Verification
The resample strobe and the reload of the next read byte are tied to the same master acknowledge clock. The strobe fires on the rising SCL edge, and the following snapshot byte is taken on the falling edge. Long reads with varied byte counts exercise this pairing, and the bench judges it by the byte sequence it reads back and by the number of strobe pulses per frame. A START that arrives while a frame is still open collides with the byte progress of that frame. This is provoked with repeated STARTs after a write acknowledge and after a read NACK. The bench then checks that the new address is decoded cleanly and that only one stop pulse appears for the whole compound frame.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR_DATA,
        PH_WR_ACK,
        PH_RD_DATA,
        PH_RD_ACK,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic                rw;
        logic                flag_sel;
        logic                nack;
        logic                pull;
        logic [BYTE_W-1:0]   mask;
        logic                ack_stb;
        logic                stop_stb;
    } ctrl_t;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2cx_bus_events.sv
module i2cx_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s_i;
        prev_d.sda = sda_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise_o = scl_s_i & ~prev_q.scl;
    assign scl_fall_o = ~scl_s_i & prev_q.scl;
    assign start_o    = scl_s_i & prev_q.scl & prev_q.sda & ~sda_s_i;
    assign stop_o     = scl_s_i & prev_q.scl & ~prev_q.sda & sda_s_i;
endmodule

// File: rtl/i2cx_ctrl.sv
module i2cx_ctrl
    import i2cx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [BYTE_W-1:0] port_snap_i,
    input  logic [BYTE_W-1:0] trans_flags_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] irq_mask_o,
    output logic              ack_strobe_o,
    output logic              stop_strobe_o,
    output logic              rd_busy_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    ctrl_t q, d;
    logic [BYTE_W-1:0] next_tx;

    always_comb begin
        d          = q;
        d.ack_stb  = 1'b0;
        d.stop_stb = 1'b0;
        // flag_sel names the byte just sent; the next byte is the other one
        next_tx    = q.flag_sel ? port_snap_i : trans_flags_i;

        if (stop_i) begin
            d.phase    = PH_IDLE;
            d.pull     = 1'b0;
            d.stop_stb = 1'b1;
        end else if (start_i) begin
            d.phase  = PH_ADDR;
            d.bitcnt = '0;
            d.pull   = 1'b0;
        end else begin
            unique case (q.phase)
                PH_ADDR: begin
                    if (scl_rise_i) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_s_i};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall_i && q.bitcnt == FULL_CNT) begin
                        if (q.shreg[BYTE_W-1:1] == dev_addr_i) begin
                            d.rw    = q.shreg[0];
                            d.pull  = 1'b1;
                            d.phase = PH_ADDR_ACK;
                        end else begin
                            d.phase = PH_SKIP;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (scl_rise_i) begin
                        d.ack_stb = 1'b1;
                    end else if (scl_fall_i) begin
                        d.bitcnt   = '0;
                        d.flag_sel = 1'b0;
                        if (q.rw) begin
                            d.phase = PH_RD_DATA;
                            d.shreg = port_snap_i;
                            d.pull  = ~port_snap_i[BYTE_W-1];
                        end else begin
                            d.phase = PH_WR_DATA;
                            d.pull  = 1'b0;
                        end
                    end
                end
                PH_WR_DATA: begin
                    if (scl_rise_i) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_s_i};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall_i && q.bitcnt == FULL_CNT) begin
                        d.mask  = q.shreg;
                        d.pull  = 1'b1;
                        d.phase = PH_WR_ACK;
                    end
                end
                PH_WR_ACK: begin
                    if (scl_fall_i) begin
                        d.pull   = 1'b0;
                        d.bitcnt = '0;
                        d.phase  = PH_WR_DATA;
                    end
                end
                PH_RD_DATA: begin
                    if (scl_fall_i) begin
                        if (q.bitcnt == LAST_TX) begin
                            d.pull   = 1'b0;
                            d.bitcnt = '0;
                            d.phase  = PH_RD_ACK;
                        end else begin
                            d.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.pull   = ~q.shreg[BYTE_W-2];
                            d.bitcnt = q.bitcnt + 1'b1;
                        end
                    end
                end
                PH_RD_ACK: begin
                    if (scl_rise_i) begin
                        d.nack    = sda_s_i;
                        d.ack_stb = ~sda_s_i & q.flag_sel;
                    end else if (scl_fall_i) begin
                        if (q.nack) begin
                            d.phase = PH_SKIP;
                            d.pull  = 1'b0;
                        end else begin
                            d.flag_sel = ~q.flag_sel;
                            d.shreg    = next_tx;
                            d.pull     = ~next_tx[BYTE_W-1];
                            d.bitcnt   = '0;
                            d.phase    = PH_RD_DATA;
                        end
                    end
                end
                default: begin
                    d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, bitcnt: '0, shreg: '0, rw: 1'b0,
                   flag_sel: 1'b0, nack: 1'b0, pull: 1'b0, mask: '0,
                   ack_stb: 1'b0, stop_stb: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o    = q.pull;
    assign irq_mask_o    = q.mask;
    assign ack_strobe_o  = q.ack_stb;
    assign stop_strobe_o = q.stop_stb;
    assign rd_busy_o     = (q.phase == PH_RD_DATA) || (q.phase == PH_RD_ACK);
endmodule

// File: rtl/i2cx_expander_slave.sv
module i2cx_expander_slave #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [6:0] dev_addr_i,
    input  logic [7:0] port_snap_i,
    input  logic [7:0] trans_flags_i,
    output logic       sda_pull_o,
    output logic [7:0] irq_mask_o,
    output logic       ack_strobe_o,
    output logic       stop_strobe_o,
    output logic       rd_busy_o
);
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_evt, stop_evt;

    i2cx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );

    i2cx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    i2cx_bus_events u_events (
        .clk(clk), .rst_n(rst_n),
        .scl_s_i(scl_s), .sda_s_i(sda_s),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_evt), .stop_o(stop_evt)
    );

    i2cx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sda_s_i(sda_s),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_evt), .stop_i(stop_evt),
        .dev_addr_i(dev_addr_i),
        .port_snap_i(port_snap_i), .trans_flags_i(trans_flags_i),
        .sda_pull_o(sda_pull_o), .irq_mask_o(irq_mask_o),
        .ack_strobe_o(ack_strobe_o), .stop_strobe_o(stop_strobe_o),
        .rd_busy_o(rd_busy_o)
    );
endmodule

// File: rtl/i2cx_checker.sv
module i2cx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       sda_pull,
    input logic       ack_stb,
    input logic       stop_stb,
    input logic       rd_busy,
    input logic [7:0] mask
);
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_pull && !rd_busy));

    p_stop_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> stop_stb);

    p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_pull);

    p_mask_hold_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> $stable(mask));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> !ack_stb);

    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull));
endmodule

bind i2cx_expander_slave i2cx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_pull(sda_pull_o), .ack_stb(ack_strobe_o),
    .stop_stb(stop_strobe_o), .rd_busy(rd_busy_o), .mask(irq_mask_o)
);

// File: tb/i2cx_expander_slave_tb.sv
module i2cx_expander_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 10;
    localparam int QP         = 3;
    localparam logic [6:0] MY_ADDR = 7'h4B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] snap = 8'h00;
    logic [7:0] flags = 8'h00;
    logic       sda_pull, ack_stb, stop_stb, rd_busy;
    logic [7:0] mask;
    wire        sda_line = sda_m & ~sda_pull;

    int n_tests = 0;
    int n_fail  = 0;
    int ack_cnt = 0;
    int stop_cnt = 0;
    bit done = 0;
    logic [7:0] exp_mask = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cx_expander_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .dev_addr_i(MY_ADDR), .port_snap_i(snap), .trans_flags_i(flags),
        .sda_pull_o(sda_pull), .irq_mask_o(mask), .ack_strobe_o(ack_stb),
        .stop_strobe_o(stop_stb), .rd_busy_o(rd_busy)
    );

    always @(posedge clk) begin
        if (ack_stb)  ack_cnt++;
        if (stop_stb) stop_cnt++;
    end

    function automatic logic [7:0] exp_rd_byte(int idx, logic [7:0] s, logic [7:0] f);
        return (idx % 2 == 0) ? s : f;
    endfunction

    function automatic int exp_strobes_read(int nbytes);
        return 1 + (nbytes - 1) / 2;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(QP);
        scl_m = 1'b1; waitc(HP);
        sda_m = 1'b0; waitc(HP);
        scl_m = 1'b0; waitc(QP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(QP);
        scl_m = 1'b1; waitc(HP);
        sda_m = 1'b1; waitc(HP);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    waitc(HP);
        scl_m = 1'b1; waitc(HP);
        scl_m = 1'b0; waitc(QP);
    endtask

    task automatic recv_bit(output logic b, output logic held);
        sda_m = 1'b1; waitc(HP);
        scl_m = 1'b1; waitc(1);
        held = 1'b1;
        for (int k = 0; k < HP - 1; k++) begin
            if (k == HP / 2) b = sda_line;
            if (sda_line !== 1'b0) held = 1'b0;
            waitc(1);
        end
        scl_m = 1'b0; waitc(QP);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked);
        logic b, h;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b, h);
        acked = h;
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] v);
        logic b, h;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b, h);
            v[i] = b;
        end
        send_bit(~master_ack);
    endtask

    task automatic write_frame(input logic [6:0] a, input int nbytes);
        logic acked;
        logic [7:0] v;
        bit match = (a == MY_ADDR);
        bus_start();
        write_byte({a, 1'b0}, acked);
        chk(match ? "R3 addr ack" : "R4 addr no ack", acked, match);
        for (int i = 0; i < nbytes; i++) begin
            v = 8'($urandom);
            write_byte(v, acked);
            chk(match ? "R5 data ack" : "R4 data ignored", acked, match);
            if (match) exp_mask = v;
            chk("R5/R4 mask", mask, exp_mask);
        end
        bus_stop();
    endtask

    task automatic read_frame(input logic [6:0] a, input int nbytes);
        logic acked;
        logic [7:0] v;
        bit match = (a == MY_ADDR);
        int a0 = ack_cnt;
        snap  = 8'($urandom);
        flags = 8'($urandom);
        bus_start();
        write_byte({a, 1'b1}, acked);
        chk(match ? "R3 read addr ack" : "R4 read addr no ack", acked, match);
        for (int i = 0; i < nbytes; i++) begin
            waitc(2);
            if (i == 0) chk("R9 busy in read", rd_busy, match);
            read_byte(i != nbytes - 1, v);
            chk(match ? "R6 read byte" : "R4 released", v,
                match ? exp_rd_byte(i, snap, flags) : 8'hFF);
        end
        waitc(HP);
        chk("R7 release after nack", sda_pull, 1'b0);
        chk("R9 idle after nack", rd_busy, 1'b0);
        chk("R8 strobe count", ack_cnt - a0, match ? exp_strobes_read(nbytes) : 0);
        chk("R5 mask kept on read", mask, exp_mask);
        bus_stop();
    endtask

    initial begin
        int s0;
        logic acked;
        logic [7:0] v;
        void'($urandom(32'd1234));
        waitc(5);
        chk("R1 pull", sda_pull, 1'b0);
        chk("R1 mask", mask, 8'h00);
        chk("R1 strobe", ack_stb, 1'b0);
        chk("R1 busy", rd_busy, 1'b0);
        rst_n = 1'b1;
        waitc(5);

        // directed
        s0 = stop_cnt;
        write_frame(MY_ADDR, 1);
        waitc(3);
        chk("R2 stop pulse", stop_cnt - s0, 1);
        write_frame(MY_ADDR, 3);
        write_frame(MY_ADDR ^ 7'h01, 2);
        read_frame(MY_ADDR, 1);
        read_frame(MY_ADDR, 2);
        read_frame(MY_ADDR, 5);
        read_frame(MY_ADDR ^ 7'h40, 2);

        // repeated START: write, then read without STOP in between
        s0 = stop_cnt;
        bus_start();
        write_byte({MY_ADDR, 1'b0}, acked);
        v = 8'hA5;
        write_byte(v, acked);
        exp_mask = v;
        chk("R2 write before restart", mask, 8'hA5);
        snap = 8'h3C; flags = 8'hC3;
        bus_start();
        write_byte({MY_ADDR, 1'b1}, acked);
        chk("R2 restart addr ack", acked, 1'b1);
        read_byte(1'b1, v);
        chk("R2 restart byte0", v, 8'h3C);
        read_byte(1'b0, v);
        chk("R2 restart byte1", v, 8'hC3);
        bus_start();
        write_byte({MY_ADDR ^ 7'h10, 1'b0}, acked);
        chk("R4 restart mismatch", acked, 1'b0);
        bus_stop();
        waitc(3);
        chk("R2 single stop", stop_cnt - s0, 1);

        // constrained random frames
        for (int f = 0; f < 24; f++) begin
            logic [6:0] a = ($urandom % 4 == 0) ? 7'($urandom) : MY_ADDR;
            int nb = 1 + ($urandom % 5);
            if ($urandom % 2) read_frame(a, nb);
            else              write_frame(a, nb);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule